// File: doc/BRIEF.md
# Display Interface Interrupt Controller

This block collects the event interrupts of a display output interface and presents them through a single control/status register. Event pulses arrive from the rest of the interface (FIFO overflow, FIFO underflow, vertical blanking entry, transfer-count exhaustion, leading VSYNC edge and new-field start). The current display mode decides which of those pulses feed the frame-done and VSYNC-edge sources. Each of the four sources has a sticky status bit and an enable bit. One registered interrupt line is asserted while any enabled status bit is set.

Software reaches the register through a simple write port with three aliases: a base address for configuration, a set alias and a clear alias. The set and clear aliases act on the status bits only. The base address also holds a busy-input enable and a bus-style select for 8080 versus 6800 timing. The bus-style select is write-protected while the interface is running.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every status bit, every enable bit, the busy enable, the bus-style select and `irq_o` are 0.
- R2: A write to the clear alias (address 2) clears each status bit whose data bit is 1. Data bits that are 0 leave their status bit unchanged. Without an event or a clear, a set status bit stays set.
- R3: In DOTCLK mode (mode 2) and DVI mode (mode 3), a vertical-blanking-entry pulse sets the frame-done status (bit 2). A transfer-done pulse has no effect.
- R4: In system mode (mode 0) and VSYNC mode (mode 1), a transfer-done pulse sets the frame-done status (bit 2). A vertical-blanking pulse has no effect.
- R5: The VSYNC-edge status (bit 3) is set by a leading-VSYNC pulse in VSYNC and DOTCLK modes and by a field-start pulse in DVI mode. In system mode neither pulse sets it. In every mode, the pulse that is not selected has no effect.
- R6: An overflow pulse sets status bit 0 and an underflow pulse sets status bit 1, in every mode.
- R7: At the base address (address 0), a write loads the enables from data bits 7:4, the busy enable from bit 8 and the bus-style select from bit 9 (1 = 6800). Writes to status bits 3:0 at this address are ignored. Writes to address 3 are ignored. Reading returns status in bits 3:0, enables in bits 7:4, busy in bit 8 and style in bit 9, with every other bit reading 0.
- R8: While `run_i` is 1, a base-address write leaves the bus-style select unchanged. The other fields of the same write still update.
- R9: `irq_o` equals the OR over the four sources of status AND enable, registered, so it follows a status or enable change by one clock.
- R10: An event pulse in the same cycle as a clear of its bit wins, and the bit stays set.
- R11: A write to the set alias (address 1) sets each status bit whose data bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Display mode: 0 system, 1 VSYNC, 2 DOTCLK, 3 DVI |
| run_i | input | 1 | Interface running flag |
| ovf_ev_i | input | 1 | Latency-FIFO overflow pulse |
| unf_ev_i | input | 1 | Transmit-FIFO underflow pulse |
| vblank_ev_i | input | 1 | Vertical blanking entry pulse |
| xfer_done_ev_i | input | 1 | Transfer count exhausted pulse |
| vsync_lead_ev_i | input | 1 | Leading VSYNC edge pulse |
| field_start_ev_i | input | 1 | New field start pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write alias: 0 base, 1 set, 2 clear, 3 unused |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Register read value |
| busy_en_o | output | 1 | Busy input stall enable |
| bus_style_o | output | 1 | Bus style select, 1 = 6800 |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is an event pulse that lands in the same cycle as a clear-alias write to its own bit. The bench drives both from one negative-edge step, with every status bit set beforehand, and expects only the pulsed bit to survive. The mode-dependent routing is swept over every mode and every event pulse. The interrupt path is swept over all 256 combinations of status and enable loaded through the set alias, and each combination is checked both one cycle after the load (old value) and two cycles after it (new value).

// File: rtl/disp_irq_pkg.sv
// Package: shared constants and types of the display interrupt controller.
// Assumes four interrupt sources and a 2-bit alias address.
package disp_irq_pkg;
    localparam int NSRC      = 4;
    localparam int SRC_OVF   = 0;
    localparam int SRC_UNF   = 1;
    localparam int SRC_FRM   = 2;
    localparam int SRC_VSY   = 3;
    localparam int EN_LSB    = NSRC;
    localparam int BUSY_POS  = 2 * NSRC;
    localparam int STYLE_POS = 2 * NSRC + 1;
    localparam int CFG_W     = 2 * NSRC + 2;

    typedef enum logic [1:0] {
        MODE_SYS    = 2'd0,
        MODE_VSYNC  = 2'd1,
        MODE_DOTCLK = 2'd2,
        MODE_DVI    = 2'd3
    } disp_mode_e;

    typedef enum logic [1:0] {
        AD_BASE = 2'd0,
        AD_SET  = 2'd1,
        AD_CLR  = 2'd2,
        AD_NONE = 2'd3
    } reg_alias_e;
endpackage

// File: rtl/disp_irq_src_sel.sv
// Module: routes raw event pulses onto the four interrupt sources
// according to the display mode. Purely combinational.
// Assumes event inputs are single-cycle pulses.
module disp_irq_src_sel
    import disp_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [1:0]   mode_i,
    input  logic         ovf_ev_i,
    input  logic         unf_ev_i,
    input  logic         vblank_ev_i,
    input  logic         xfer_done_ev_i,
    input  logic         vsync_lead_ev_i,
    input  logic         field_start_ev_i,
    output logic [N-1:0] src_ev_o
);
    disp_mode_e mode;
    assign mode = disp_mode_e'(mode_i);

    // Purpose: choose the frame-done and VSYNC-edge triggers by mode.
    always_comb begin
        src_ev_o          = '0;
        src_ev_o[SRC_OVF] = ovf_ev_i;
        src_ev_o[SRC_UNF] = unf_ev_i;
        case (mode)
            MODE_SYS: begin
                src_ev_o[SRC_FRM] = xfer_done_ev_i;
                src_ev_o[SRC_VSY] = 1'b0;
            end
            MODE_VSYNC: begin
                src_ev_o[SRC_FRM] = xfer_done_ev_i;
                src_ev_o[SRC_VSY] = vsync_lead_ev_i;
            end
            MODE_DOTCLK: begin
                src_ev_o[SRC_FRM] = vblank_ev_i;
                src_ev_o[SRC_VSY] = vsync_lead_ev_i;
            end
            default: begin
                src_ev_o[SRC_FRM] = vblank_ev_i;
                src_ev_o[SRC_VSY] = field_start_ev_i;
            end
        endcase
    end
endmodule

// File: rtl/disp_irq_status.sv
// Module: sticky status bits, one per source. An event or a set request
// sets a bit; a clear request clears it; event/set take priority.
// Assumes synchronous active-low reset.
module disp_irq_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        // Purpose: hold one sticky bit with set-over-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n)                   status_o[g] <= 1'b0;
            else if (ev_i[g] || set_i[g]) status_o[g] <= 1'b1;
            else if (clr_i[g])            status_o[g] <= 1'b0;
        end

        p_evwins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[g] |=> status_o[g]);
        p_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> status_o[g]);
        p_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !ev_i[g] && !set_i[g]) |=> !status_o[g]);
        p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[g] && !clr_i[g]) |=> status_o[g]);
    end
endmodule

// File: rtl/disp_irq_cfg.sv
// Module: configuration fields of the base address: per-source enables,
// busy enable and bus-style select. The style select is locked while run.
// Assumes synchronous active-low reset.
module disp_irq_cfg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         wr_i,
    input  logic [N-1:0] en_d_i,
    input  logic         busy_d_i,
    input  logic         style_d_i,
    output logic [N-1:0] en_o,
    output logic         busy_o,
    output logic         style_o
);
    // Purpose: load enables and busy enable on a base-address write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= '0;
            busy_o <= 1'b0;
        end else if (wr_i) begin
            en_o   <= en_d_i;
            busy_o <= busy_d_i;
        end
    end

    // Purpose: load the bus-style select only while the interface is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)              style_o <= 1'b0;
        else if (wr_i && !run_i) style_o <= style_d_i;
    end

    p_style_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> $stable(style_o));
    p_en_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_o == $past(en_d_i)));
endmodule

// File: rtl/disp_irq_ctrl.sv
// Module: top of the display interrupt controller. Decodes the write
// aliases, assembles the read value and registers the combined interrupt.
// Assumes DATA_W is at least CFG_W bits; the upper bits are reserved.
module disp_irq_ctrl
    import disp_irq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              run_i,
    input  logic              ovf_ev_i,
    input  logic              unf_ev_i,
    input  logic              vblank_ev_i,
    input  logic              xfer_done_ev_i,
    input  logic              vsync_lead_ev_i,
    input  logic              field_start_ev_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_en_o,
    output logic              bus_style_o,
    output logic              irq_o
);
    localparam int RSV_W = DATA_W - CFG_W;

    logic [NSRC-1:0] src_ev;
    logic [NSRC-1:0] status;
    logic [NSRC-1:0] enable;
    logic [NSRC-1:0] set_req;
    logic [NSRC-1:0] clr_req;
    logic            wr_base;
    logic            unused_wr_bits;

    // Purpose: decode the alias address into base, set and clear strobes.
    always_comb begin
        wr_base = wr_en_i && (reg_alias_e'(wr_addr_i) == AD_BASE);
        set_req = (wr_en_i && (reg_alias_e'(wr_addr_i) == AD_SET))
                  ? wr_data_i[NSRC-1:0] : '0;
        clr_req = (wr_en_i && (reg_alias_e'(wr_addr_i) == AD_CLR))
                  ? wr_data_i[NSRC-1:0] : '0;
    end

    if (RSV_W > 0) begin : g_rsv
        assign unused_wr_bits = ^wr_data_i[DATA_W-1:CFG_W];
    end else begin : g_norsv
        assign unused_wr_bits = 1'b0;
    end

    disp_irq_src_sel #(.N(NSRC)) u_sel (
        .mode_i           (mode_i),
        .ovf_ev_i         (ovf_ev_i),
        .unf_ev_i         (unf_ev_i),
        .vblank_ev_i      (vblank_ev_i),
        .xfer_done_ev_i   (xfer_done_ev_i),
        .vsync_lead_ev_i  (vsync_lead_ev_i),
        .field_start_ev_i (field_start_ev_i),
        .src_ev_o         (src_ev)
    );

    disp_irq_status #(.N(NSRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (src_ev),
        .set_i    (set_req),
        .clr_i    (clr_req),
        .status_o (status)
    );

    disp_irq_cfg #(.N(NSRC)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .wr_i      (wr_base),
        .en_d_i    (wr_data_i[EN_LSB +: NSRC]),
        .busy_d_i  (wr_data_i[BUSY_POS]),
        .style_d_i (wr_data_i[STYLE_POS]),
        .en_o      (enable),
        .busy_o    (busy_en_o),
        .style_o   (bus_style_o)
    );

    // Purpose: assemble the read value with reserved bits forced to zero.
    always_comb begin
        rd_data_o                      = '0;
        rd_data_o[NSRC-1:0]            = status;
        rd_data_o[EN_LSB +: NSRC]      = enable;
        rd_data_o[BUSY_POS]            = busy_en_o;
        rd_data_o[STYLE_POS]           = bus_style_o;
    end

    // Purpose: register the OR of enabled status bits as the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(status & enable);
    end

    p_irq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & enable)) |=> irq_o);
    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & enable)) |=> !irq_o);
    p_frm_vblank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && vblank_ev_i) |=> status[SRC_FRM]);
    p_frm_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i[1] && xfer_done_ev_i) |=> status[SRC_FRM]);
    p_vsy_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 2'd3) && field_start_ev_i) |=> status[SRC_VSY]);
    p_fifo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ev_i && unf_ev_i) |=> (status[SRC_OVF] && status[SRC_UNF]));
endmodule

// File: tb/sim_disp_irq_ctrl.sv
// Bench: sweeps every mode against every event pulse, every status/enable
// pair for the interrupt, and the alias, lock and priority corner cases.
module sim_disp_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          run = 1'b0;
    logic          ovf = 1'b0, unf = 1'b0, vbl = 1'b0, xfd = 1'b0;
    logic          vsl = 1'b0, fld = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          busy_en, bus_style, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_irq_ctrl #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .run_i(run),
        .ovf_ev_i(ovf), .unf_ev_i(unf), .vblank_ev_i(vbl),
        .xfer_done_ev_i(xfd), .vsync_lead_ev_i(vsl), .field_start_ev_i(fld),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .busy_en_o(busy_en), .bus_style_o(bus_style),
        .irq_o(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic drive_ev(input int k, input logic v);
        case (k)
            0: ovf = v;
            1: unf = v;
            2: vbl = v;
            3: xfd = v;
            4: vsl = v;
            default: fld = v;
        endcase
    endtask

    task automatic pulse(input int k);
        drive_ev(k, 1'b1);
        @(negedge clk);
        drive_ev(k, 1'b0);
    endtask

    // Expected status mask for event k in mode m, from R3 to R6.
    function automatic logic [3:0] exp_mask(input int m, input int k);
        case (k)
            0: return 4'b0001;
            1: return 4'b0010;
            2: return (m >= 2) ? 4'b0100 : 4'b0000;
            3: return (m <  2) ? 4'b0100 : 4'b0000;
            4: return (m == 1 || m == 2) ? 4'b1000 : 4'b0000;
            default: return (m == 3) ? 4'b1000 : 4'b0000;
        endcase
    endfunction

    initial begin
        repeat (CLK_PERIOD * 100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rd", rd_data, '0);
        check("R1 irq", {15'd0, irq}, '0);
        check("R1 busy/style", {14'd0, busy_en, bus_style}, '0);

        // R3 R4 R5 R6: every mode against every event, then clear (R2)
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0];
            for (int k = 0; k < 6; k++) begin
                pulse(k);
                check($sformatf("R3/R4/R5/R6 mode%0d ev%0d", m, k),
                      rd_data, {12'd0, exp_mask(m, k)});
                do_write(2'd2, 16'h000F);
                check("R2 clear all", rd_data, '0);
            end
        end
        mode = 2'd0;

        // R11: set alias; R2: zero write to clear alias has no effect
        do_write(2'd1, 16'h000F);
        check("R11 set all", rd_data, 16'h000F);
        do_write(2'd2, 16'h0000);
        check("R2 zero clear", rd_data, 16'h000F);
        for (int b = 0; b < 4; b++) begin
            do_write(2'd2, 16'(1 << b));
            check($sformatf("R2 clear bit%0d", b), rd_data,
                  16'h000F & ~16'((1 << (b + 1)) - 1));
        end

        // R7: base write fields, status ignored, reserved bits read zero
        do_write(2'd0, 16'hFFFF);
        check("R7 base write", rd_data, 16'h03F0);
        check("R7 outputs", {14'd0, busy_en, bus_style}, 16'h0003);
        do_write(2'd3, 16'hFFFF);
        check("R7 addr3 ignored", rd_data, 16'h03F0);

        // R8: style locked while running, other fields still load
        run = 1'b1;
        do_write(2'd0, 16'h0000);
        check("R8 style locked", rd_data, 16'h0200);
        run = 1'b0;
        do_write(2'd0, 16'h0000);
        check("R8 style idle write", rd_data, 16'h0000);

        // R10: event in same cycle as clear of that bit wins
        do_write(2'd1, 16'h000F);
        ovf = 1'b1;
        do_write(2'd2, 16'h000F);
        ovf = 1'b0;
        check("R10 event beats clear", rd_data, 16'h0001);
        do_write(2'd2, 16'h000F);

        // R9: all status x enable pairs, with one-cycle latency
        for (int e = 0; e < 16; e++) begin
            for (int s = 0; s < 16; s++) begin
                do_write(2'd0, 16'(e << 4));
                do_write(2'd2, 16'h000F);
                do_write(2'd1, 16'(s));
                check("R9 latency", {15'd0, irq}, '0);
                @(negedge clk);
                check($sformatf("R9 s=%0d e=%0d", s, e), {15'd0, irq},
                      {15'd0, ((s & e) != 0)});
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule